// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block moves data between two buses, A and B, which are 20 bits wide by default. Each direction has its own storage element and its own set of four controls. The storage element can act in one of three ways. It can be a transparent path, where the output follows the input. It can be a held latch. It can be a flip-flop that loads on a rising edge of that direction's strobe. A pass-enable input, a freeze input and the strobe together pick the behaviour. An active-low output-enable decides whether the destination bus is driven.

The whole block runs on one fast system clock. Each strobe is treated as data: its level is sampled on every system clock, and a rising edge is recognised when the current level is high and the level sampled on the previous clock was low. The transparent path is combinational from the source bus to the destination output.

Each bus is presented as a separate input vector, output vector and drive indication. This lets the surrounding logic, or a bench, model a high-impedance bus without tri-state nets. While a destination is not driven, its data output reads as zero.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: When a direction's pass-enable is high, its destination output equals its source input in the same cycle, with no clock edge needed. The storage element loads the source on every clock while pass-enable stays high.
- R2: When pass-enable is low and freeze is high, the stored value does not change, even when the strobe rises.
- R3: When pass-enable and freeze are both low, a rising strobe edge loads the source into storage. A rising edge means the strobe is high now and was low at the previous system clock; this sampling also runs while reset is asserted. The loaded value appears on the output right after the system clock edge that saw the rising strobe.
- R4: When pass-enable and freeze are both low, a strobe that stays high, stays low or falls leaves the stored value unchanged.
- R5: A low output-enable, sampled on a system clock edge, raises the drive indication after that edge. A high output-enable lowers it. While the drive indication is low, the data output is all zeros.
- R6: When pass-enable falls, the storage keeps the last value that was passed through.
- R7: The two directions are independent. No control or data input of one direction changes the other direction's output.
- R8: A system clock edge with reset high clears both storage elements to zero and lowers both drive indications.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Data arriving from bus A |
| b_in | input | W | Data arriving from bus B |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_pass | input | 1 | A-to-B transparent select |
| ab_freeze | input | 1 | A-to-B hold select when not transparent |
| ab_strobe | input | 1 | A-to-B load strobe, rising edge active |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_pass | input | 1 | B-to-A transparent select |
| ba_freeze | input | 1 | B-to-A hold select when not transparent |
| ba_strobe | input | 1 | B-to-A load strobe, rising edge active |
| b_out | output | W | Data toward bus B, zero when not driven |
| b_drive | output | 1 | High when bus B is driven |
| a_out | output | W | Data toward bus A, zero when not driven |
| a_drive | output | 1 | High when bus A is driven |

## Verification
A wrong stored value stays hidden while a direction is transparent. It shows up on the destination output in the first cycle after pass-enable falls, provided the output is driven. A fault in the strobe sampler shows up as a missed or extra load on the output right after the clock edge that should, or should not, have loaded. The bench therefore steps through static-high, static-low, falling and frozen strobes, and a strobe held high across the release of reset. A wrong output-enable register shows on the drive indication, and on the zeroed data, one cycle after the enable changes.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  localparam int XCVR_WIDTH_DEF = 20;
  localparam int XCVR_LANES     = 2;

  typedef enum logic [1:0] {
    MODE_PASS    = 2'd0,
    MODE_FREEZE  = 2'd1,
    MODE_CLOCKED = 2'd2
  } lane_mode_e;

  typedef struct packed {
    logic oe_n;
    logic pass;
    logic freeze;
    logic strobe;
  } lane_ctrl_t;

  // Pass-enable has priority; freeze only matters when not transparent.
  function automatic lane_mode_e decode_mode(input lane_ctrl_t c);
    if (c.pass)        return MODE_PASS;
    else if (c.freeze) return MODE_FREEZE;
    else               return MODE_CLOCKED;
  endfunction

endpackage

// File: rtl/xcvr_edge_sense.sv
module xcvr_edge_sense (
  input  logic clk,
  input  logic strobe,
  output logic rise
);
  logic strobe_q;

  // R3: the previous level is sampled on every clock, reset included,
  // so a strobe held high across reset release is not seen as an edge.
  always_ff @(posedge clk) begin
    strobe_q <= strobe;
  end

  assign rise = strobe & ~strobe_q;
endmodule

// File: rtl/xcvr_lane_store.sv
module xcvr_lane_store
  import xcvr_pkg::*;
#(
  parameter int W = XCVR_WIDTH_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  lane_mode_e   mode,
  input  logic         rise,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;                         // R8
    end else begin
      unique case (mode)
        MODE_PASS:    q <= din;        // R1 and R6: tracks, keeps last value
        MODE_CLOCKED: if (rise) q <= din; // R3, R4
        default:      q <= q;          // R2
      endcase
    end
  end
endmodule

// File: rtl/xcvr_lane_drive.sv
module xcvr_lane_drive
  import xcvr_pkg::*;
#(
  parameter int W = XCVR_WIDTH_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         oe_n,
  input  lane_mode_e   mode,
  input  logic [W-1:0] din,
  input  logic [W-1:0] stored,
  output logic [W-1:0] dout,
  output logic         drive
);
  logic         oe_q;
  logic [W-1:0] value;

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;             // R8
    else     oe_q <= ~oe_n;            // R5
  end

  assign value = (mode == MODE_PASS) ? din : stored;
  assign dout  = oe_q ? value : '0;
  assign drive = oe_q;
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W = XCVR_WIDTH_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  lane_ctrl_t   ctrl,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         drive
);
  lane_mode_e   mode;
  logic         rise;
  logic [W-1:0] stored;

  assign mode = decode_mode(ctrl);

  xcvr_edge_sense u_edge (
    .clk    (clk),
    .strobe (ctrl.strobe),
    .rise   (rise)
  );

  xcvr_lane_store #(.W(W)) u_store (
    .clk  (clk),
    .rst  (rst),
    .mode (mode),
    .rise (rise),
    .din  (din),
    .q    (stored)
  );

  xcvr_lane_drive #(.W(W)) u_drive (
    .clk    (clk),
    .rst    (rst),
    .oe_n   (ctrl.oe_n),
    .mode   (mode),
    .din    (din),
    .stored (stored),
    .dout   (dout),
    .drive  (drive)
  );
endmodule

// File: rtl/bidir_latch_xcvr.sv
module bidir_latch_xcvr
  import xcvr_pkg::*;
#(
  parameter int W = XCVR_WIDTH_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_oe_n,
  input  logic         ab_pass,
  input  logic         ab_freeze,
  input  logic         ab_strobe,
  input  logic         ba_oe_n,
  input  logic         ba_pass,
  input  logic         ba_freeze,
  input  logic         ba_strobe,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  output logic [W-1:0] a_out,
  output logic         a_drive
);
  localparam int LANES = XCVR_LANES;

  // Lane 0 carries A to B, lane 1 carries B to A (R7: no shared state).
  logic [W-1:0] src  [LANES];
  logic [W-1:0] dst  [LANES];
  logic         drv  [LANES];
  lane_ctrl_t   ctrl [LANES];

  assign src[0]  = a_in;
  assign src[1]  = b_in;
  assign ctrl[0] = '{oe_n: ab_oe_n, pass: ab_pass, freeze: ab_freeze, strobe: ab_strobe};
  assign ctrl[1] = '{oe_n: ba_oe_n, pass: ba_pass, freeze: ba_freeze, strobe: ba_strobe};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    xcvr_lane #(.W(W)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .ctrl  (ctrl[g]),
      .din   (src[g]),
      .dout  (dst[g]),
      .drive (drv[g])
    );
  end

  assign b_out   = dst[0];
  assign b_drive = drv[0];
  assign a_out   = dst[1];
  assign a_drive = drv[1];
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int W = 20
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         ab_oe_n,
  input logic         ab_pass,
  input logic         ab_freeze,
  input logic         ab_strobe,
  input logic         ba_oe_n,
  input logic         ba_pass,
  input logic         ba_freeze,
  input logic         ba_strobe,
  input logic [W-1:0] b_out,
  input logic         b_drive,
  input logic [W-1:0] a_out,
  input logic         a_drive
);
  logic         ab_stb_q, ba_stb_q;
  logic         ab_load_q, ba_load_q, ab_keep_q, ab_static_q;
  logic [W-1:0] a_in_q, b_in_q;

  always_ff @(posedge clk) begin
    ab_stb_q    <= ab_strobe;
    ba_stb_q    <= ba_strobe;
    a_in_q      <= a_in;
    b_in_q      <= b_in;
    ab_load_q   <= !rst && !ab_pass && !ab_freeze && ab_strobe && !ab_stb_q;
    ba_load_q   <= !rst && !ba_pass && !ba_freeze && ba_strobe && !ba_stb_q;
    ab_keep_q   <= !rst && !ab_pass && ab_freeze;
    ab_static_q <= !rst && !ab_pass && !ab_freeze && !(ab_strobe && !ab_stb_q);
  end

  a_r1_ab_follow: assert property (@(posedge clk) disable iff (rst)
    (ab_pass && b_drive) |-> (b_out == a_in));
  a_r1_ba_follow: assert property (@(posedge clk) disable iff (rst)
    (ba_pass && a_drive) |-> (a_out == b_in));

  a_r2_frozen: assert property (@(posedge clk) disable iff (rst)
    (ab_keep_q && !ab_pass && b_drive && $past(b_drive)) |-> $stable(b_out));

  a_r3_ab_load: assert property (@(posedge clk) disable iff (rst)
    (ab_load_q && !ab_pass && b_drive) |-> (b_out == a_in_q));
  a_r3_ba_load: assert property (@(posedge clk) disable iff (rst)
    (ba_load_q && !ba_pass && a_drive) |-> (a_out == b_in_q));

  a_r4_no_edge: assert property (@(posedge clk) disable iff (rst)
    (ab_static_q && !ab_pass && b_drive && $past(b_drive)) |-> $stable(b_out));

  a_r5_b_quiet: assert property (@(posedge clk) disable iff (rst)
    !b_drive |-> (b_out == '0));
  a_r5_a_quiet: assert property (@(posedge clk) disable iff (rst)
    !a_drive |-> (a_out == '0));
  a_r5_b_enable: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (b_drive == !$past(ab_oe_n)));
  a_r5_a_enable: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (a_drive == !$past(ba_oe_n)));

  a_r8_reset: assert property (@(posedge clk)
    rst |=> (!b_drive && !a_drive && b_out == '0 && a_out == '0));
endmodule

bind bidir_latch_xcvr xcvr_checker #(.W(W)) u_xcvr_checker (
  .clk       (clk),
  .rst       (rst),
  .a_in      (a_in),
  .b_in      (b_in),
  .ab_oe_n   (ab_oe_n),
  .ab_pass   (ab_pass),
  .ab_freeze (ab_freeze),
  .ab_strobe (ab_strobe),
  .ba_oe_n   (ba_oe_n),
  .ba_pass   (ba_pass),
  .ba_freeze (ba_freeze),
  .ba_strobe (ba_strobe),
  .b_out     (b_out),
  .b_drive   (b_drive),
  .a_out     (a_out),
  .a_drive   (a_drive)
);

// File: tb/test_bidir_latch_xcvr.sv
module test_bidir_latch_xcvr;
  localparam int CLK_PERIOD = 10;
  localparam int W = 20;
  localparam int NV = 11;

  // ctrl nibble order: {oe_n, pass, freeze, strobe}
  typedef struct packed {
    logic [3:0]   ab_c;
    logic [W-1:0] a;
    logic [W-1:0] exp_b;
    logic         exp_bd;
    logic [3:0]   ba_c;
    logic [W-1:0] b;
    logic [W-1:0] exp_a;
    logic         exp_ad;
  } vec_t;

  // Direction B-to-A sits frozen (stored zero) with a toggling strobe: R2, R7.
  localparam vec_t VEC [NV] = '{
    '{4'b0100, 20'h12345, 20'h12345, 1'b1, 4'b0010, 20'h00001, 20'h0, 1'b1}, // R1 R5
    '{4'b0100, 20'hABCDE, 20'hABCDE, 1'b1, 4'b0011, 20'h00002, 20'h0, 1'b1}, // R1
    '{4'b0000, 20'h11111, 20'hABCDE, 1'b1, 4'b0010, 20'h00003, 20'h0, 1'b1}, // R6
    '{4'b0001, 20'h22222, 20'h22222, 1'b1, 4'b0011, 20'h00004, 20'h0, 1'b1}, // R3
    '{4'b0001, 20'h33333, 20'h22222, 1'b1, 4'b0010, 20'h00005, 20'h0, 1'b1}, // R4 static high
    '{4'b0000, 20'h44444, 20'h22222, 1'b1, 4'b0011, 20'h00006, 20'h0, 1'b1}, // R4 falling
    '{4'b0011, 20'h55555, 20'h22222, 1'b1, 4'b0010, 20'h00007, 20'h0, 1'b1}, // R2
    '{4'b0010, 20'h66666, 20'h22222, 1'b1, 4'b0011, 20'h00008, 20'h0, 1'b1}, // R2
    '{4'b0001, 20'h77777, 20'h77777, 1'b1, 4'b0010, 20'h00009, 20'h0, 1'b1}, // R3
    '{4'b1101, 20'h88888, 20'h00000, 1'b0, 4'b0011, 20'h0000A, 20'h0, 1'b1}, // R5 off
    '{4'b0001, 20'h99999, 20'h88888, 1'b1, 4'b0010, 20'h0000B, 20'h0, 1'b1}  // R1 R4
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [3:0]   ab_c = 4'b1000, ba_c = 4'b1000;
  logic [W-1:0] b_out, a_out;
  logic         b_drive, a_drive;
  int           checks = 0, fails = 0;
  logic         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bidir_latch_xcvr #(.W(W)) i_bidir_latch_xcvr (
    .clk       (clk),
    .rst       (rst),
    .a_in      (a_in),
    .b_in      (b_in),
    .ab_oe_n   (ab_c[3]),
    .ab_pass   (ab_c[2]),
    .ab_freeze (ab_c[1]),
    .ab_strobe (ab_c[0]),
    .ba_oe_n   (ba_c[3]),
    .ba_pass   (ba_c[2]),
    .ba_freeze (ba_c[1]),
    .ba_strobe (ba_c[0]),
    .b_out     (b_out),
    .b_drive   (b_drive),
    .a_out     (a_out),
    .a_drive   (a_drive)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    repeat (3) step();
    chk("R8 b_drive", W'(b_drive), '0);
    chk("R8 a_drive", W'(a_drive), '0);
    chk("R8 b_out", b_out, '0);
    chk("R8 a_out", a_out, '0);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ab_c = VEC[i].ab_c; a_in = VEC[i].a;
      ba_c = VEC[i].ba_c; b_in = VEC[i].b;
      step();
      chk($sformatf("R1-6 vec%0d b_out", i), b_out, VEC[i].exp_b);
      chk($sformatf("R5 vec%0d b_drive", i), W'(b_drive), W'(VEC[i].exp_bd));
      chk($sformatf("R7 vec%0d a_out", i), a_out, VEC[i].exp_a);
      chk($sformatf("R5 vec%0d a_drive", i), W'(a_drive), W'(VEC[i].exp_ad));
    end

    // R1: B-to-A transparent; A-to-B frozen with strobe already high (R7)
    @(negedge clk); ab_c = 4'b0011; a_in = 20'h31313; ba_c = 4'b0100; b_in = 20'h0F0F0;
    step();
    chk("R1 ba pass", a_out, 20'h0F0F0);
    chk("R7 ab unaffected", b_out, 20'h88888);
    // R6: leave transparent
    @(negedge clk); ba_c = 4'b0000; b_in = 20'hFFFFF; a_in = 20'h42424;
    step();
    chk("R6 ba keeps last", a_out, 20'h0F0F0);
    // R3: B-to-A rising strobe load
    @(negedge clk); ba_c = 4'b0001; b_in = 20'h13579;
    step();
    chk("R3 ba load", a_out, 20'h13579);
    chk("R2 ab frozen", b_out, 20'h88888);

    // R8: reset mid-operation with strobes high
    @(negedge clk); rst = 1'b1; ab_c = 4'b0001; a_in = 20'h5A5A5; ba_c = 4'b0001;
    step();
    chk("R8 mid b_drive", W'(b_drive), '0);
    chk("R8 mid a_out", a_out, '0);
    step();
    @(negedge clk) rst = 1'b0;
    step();
    chk("R3 no edge across reset", b_out, '0);
    chk("R8 store cleared", a_out, '0);
    @(negedge clk) ab_c = 4'b0000;
    step();
    chk("R4 strobe low", b_out, '0);
    @(negedge clk) ab_c = 4'b0001;
    step();
    chk("R3 load after reset", b_out, 20'h5A5A5);

    // R1: same-cycle combinational path, no clock edge in between
    @(negedge clk); ab_c = 4'b0100; a_in = 20'hCAFE0;
    #1;
    chk("R1 combinational", b_out, 20'hCAFE0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule